// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog with three memory-mapped registers: a control word, a live count and a timeout limit. A slow tick input, nominally 1 kHz, advances the count while the watchdog is enabled. If software lets the count climb to the limit, the block raises a reset request, and that request stays raised until the next system reset. Software keeps the watchdog alive by writing a refresh key to the count register, which sends the count back to zero.

Changes to the enable bit, the limit or the rest of the control word are accepted only inside a short unlock window. A separate key written to the count register opens that window. Keys arrive either as one 32-bit word or as two 16-bit halves written back to back; a control bit picks the mode. A second control bit decides whether the block may ever be unlocked again. At 1 kHz, a timeout of N seconds needs a limit of 1000·N, for N from 1 to 128.

Top module: `kwd_top`

## Requirements
- R1: After reset the control register reads 0x0000_2020, the count reads 0, the limit reads DEF_TOVAL and rst_req is low.
- R2: Register offsets are: control at 0x0, count at 0x4, limit at 0x8. The control fields are: bit 13 is 32-bit key mode, bit 11 is the window-open flag (read only), bit 10 is the configured flag (read only), bits 9:8 are a stored clock-select value, bit 7 is the enable and bit 5 is the update-allow bit. All other bits read 0.
- R3: In 32-bit mode, writing 0xD928C520 to the count register opens the unlock window, and writing 0xB480A602 clears the count to 0.
- R4: In 16-bit mode only wdata[15:0] is used as the key. The unlock key is 0xC520 followed by 0xD928, and the refresh key is 0xA602 followed by 0xB480. The two halves must be consecutive bus writes; any other write between them cancels the pending half.
- R5: In 16-bit mode, a wrong second half drops the sequence and closes the window. It does not raise rst_req.
- R6: A count-register write that is not a valid key, or a valid first half, while no half is pending raises rst_req from the cycle after the write.
- R7: Writes to the control and limit registers are ignored while the window is closed.
- R8: The window stays open for WIN cycles. A control write made inside the window takes effect, closes the window, sets the configured flag and clears the count.
- R9: Once a configuration has written the update-allow bit as 0, every later unlock key fails and the window stays closed until reset. A failed unlock does not raise rst_req.
- R10: The count advances by one per tick only while the enable bit is 1.
- R11: While the block is enabled and the count has reached the limit, rst_req rises one clock later and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a two-flop synchronizer |
| tick | input | 1 | One-cycle count enable at the counting rate |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | Sticky reset request |

## Verification
If the key-sequence state is wrong, it shows at the ports on the very next count-register write. That write either clears the count when it should not, leaves the count alone when it should clear it, or raises rst_req one cycle later. If the window state is wrong, the window-open flag reads wrong immediately, and a limit write that lands or is dropped by mistake can be seen on the next read of the limit register. A wrong compare or a wrong enable shows up as rst_req rising one cycle early or late relative to the tick that brings the count to the limit.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [31:0] KEY_UNLOCK  = 32'hD928_C520;
  localparam logic [31:0] KEY_REFRESH = 32'hB480_A602;
  localparam logic [15:0] UNL_LO = 16'hC520;
  localparam logic [15:0] UNL_HI = 16'hD928;
  localparam logic [15:0] REF_LO = 16'hA602;
  localparam logic [15:0] REF_HI = 16'hB480;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CNT  = 4'h4;
  localparam logic [3:0] OFS_TOV  = 4'h8;

  localparam int B_CMD32 = 13;
  localparam int B_OPEN  = 11;
  localparam int B_DONE  = 10;
  localparam int B_CSEL  = 8;
  localparam int B_EN    = 7;
  localparam int B_UPD   = 5;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_UNL, SEQ_REF} seq_e;
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_wr,
  input  logic        other_wr,
  input  logic        cmd32,
  input  logic [31:0] wdata,
  output logic        key_unlock,
  output logic        key_refresh,
  output logic        key_bad,
  output logic        key_abort
);
  seq_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    key_unlock  = 1'b0;
    key_refresh = 1'b0;
    key_bad     = 1'b0;
    key_abort   = 1'b0;
    if (cnt_wr) begin
      st_d = SEQ_IDLE;
      if (cmd32) begin
        if (wdata == KEY_UNLOCK)       key_unlock  = 1'b1;
        else if (wdata == KEY_REFRESH) key_refresh = 1'b1;
        else                           key_bad     = 1'b1;
      end else begin
        case (st_q)
          SEQ_IDLE: begin
            if (wdata[15:0] == UNL_LO)      st_d    = SEQ_UNL;
            else if (wdata[15:0] == REF_LO) st_d    = SEQ_REF;
            else                            key_bad = 1'b1;
          end
          SEQ_UNL: begin
            if (wdata[15:0] == UNL_HI) key_unlock = 1'b1;
            else                       key_abort  = 1'b1;
          end
          SEQ_REF: begin
            if (wdata[15:0] == REF_HI) key_refresh = 1'b1;
            else                       key_abort   = 1'b1;
          end
          default: key_bad = 1'b1;
        endcase
      end
    end else if (other_wr) begin
      st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/kwd_window.sv
module kwd_window #(
  parameter int WIN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic win_open
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          open_q, open_d;
  logic [WW-1:0] left_q, left_d;

  always_comb begin
    open_d = open_q;
    left_d = left_q;
    if (open_q) begin
      if (left_q == '0) open_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
    if (close_req) open_d = 1'b0;
    if (open_req) begin
      open_d = 1'b1;
      left_d = WW'(WIN - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else begin
      open_q <= open_d;
      left_q <= left_d;
    end
  end

  assign win_open = open_q;
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             reached
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign reached = run && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (tick && run && !reached) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int WIN       = 256,
  parameter int DEF_TOVAL = 60000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);
  localparam int PAD_W = 32 - CNT_W;

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic wr, wr_ctrl, wr_cnt, wr_tov;
  assign wr      = bus_sel && bus_we;
  assign wr_ctrl = wr && (bus_addr == OFS_CTRL);
  assign wr_cnt  = wr && (bus_addr == OFS_CNT);
  assign wr_tov  = wr && (bus_addr == OFS_TOV);

  logic             cmd32_q, cmd32_d, en_q, en_d, upd_q, upd_d, done_q, done_d;
  logic [1:0]       csel_q, csel_d;
  logic [CNT_W-1:0] tov_q, tov_d, cnt_val;
  logic             rst_q, rst_d;
  logic             key_unlock, key_refresh, key_bad, key_abort;
  logic             win_open, open_req, close_req, cfg_wr, tov_wr, reached;

  kwd_keyseq u_keys (
    .clk        (clk),
    .rst_n      (srst_n),
    .cnt_wr     (wr_cnt),
    .other_wr   (wr && !wr_cnt),
    .cmd32      (cmd32_q),
    .wdata      (bus_wdata),
    .key_unlock (key_unlock),
    .key_refresh(key_refresh),
    .key_bad    (key_bad),
    .key_abort  (key_abort)
  );

  assign open_req  = key_unlock && upd_q;
  assign cfg_wr    = wr_ctrl && win_open;
  assign tov_wr    = wr_tov && win_open;
  assign close_req = key_bad || key_abort || cfg_wr;

  kwd_window #(.WIN(WIN)) u_win (
    .clk      (clk),
    .rst_n    (srst_n),
    .open_req (open_req),
    .close_req(close_req),
    .win_open (win_open)
  );

  kwd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick   (tick),
    .run    (en_q),
    .clr    (cfg_wr || key_refresh),
    .limit  (tov_q),
    .cnt    (cnt_val),
    .reached(reached)
  );

  always_comb begin
    cmd32_d = cmd32_q;
    en_d    = en_q;
    upd_d   = upd_q;
    csel_d  = csel_q;
    done_d  = done_q;
    tov_d   = tov_q;
    if (open_req) done_d = 1'b0;
    if (cfg_wr) begin
      cmd32_d = bus_wdata[B_CMD32];
      csel_d  = bus_wdata[B_CSEL+1:B_CSEL];
      en_d    = bus_wdata[B_EN];
      upd_d   = bus_wdata[B_UPD];
      done_d  = 1'b1;
    end
    if (tov_wr) tov_d = bus_wdata[CNT_W-1:0];
    rst_d = rst_q || key_bad || reached;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cmd32_q <= 1'b1;
      en_q    <= 1'b0;
      upd_q   <= 1'b1;
      csel_q  <= 2'b00;
      done_q  <= 1'b0;
      tov_q   <= CNT_W'(DEF_TOVAL);
      rst_q   <= 1'b0;
    end else begin
      cmd32_q <= cmd32_d;
      en_q    <= en_d;
      upd_q   <= upd_d;
      csel_q  <= csel_d;
      done_q  <= done_d;
      tov_q   <= tov_d;
      rst_q   <= rst_d;
    end
  end

  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[B_CMD32]             = cmd32_q;
    ctrl_rd[B_OPEN]              = win_open;
    ctrl_rd[B_DONE]              = done_q;
    ctrl_rd[B_CSEL+1:B_CSEL]     = csel_q;
    ctrl_rd[B_EN]                = en_q;
    ctrl_rd[B_UPD]               = upd_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_rd;
      OFS_CNT:  bus_rdata = {{PAD_W{1'b0}}, cnt_val};
      OFS_TOV:  bus_rdata = {{PAD_W{1'b0}}, tov_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign rst_req = rst_q;
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             srst_n,
  input logic             tick,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rst_req,
  input logic             win_open,
  input logic             cmd32,
  input logic             upd,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tov
);
  // R11
  sticky_rst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> rst_req);

  // R6
  bad_key32_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && bus_we && bus_addr == OFS_CNT && cmd32 &&
     bus_wdata != KEY_UNLOCK && bus_wdata != KEY_REFRESH) |=> rst_req);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!tick && !(bus_sel && bus_we)) |=> $stable(cnt));

  // R9
  upd_lock_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!upd && !win_open) |=> !win_open);

  // R8
  cfg_close_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (win_open && bus_sel && bus_we && bus_addr == OFS_CTRL) |=> !win_open);

  // R7
  tov_guard_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !win_open |=> $stable(tov));
endmodule

bind kwd_top kwd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .tick     (tick),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rst_req  (rst_req),
  .win_open (win_open),
  .cmd32    (cmd32_q),
  .upd      (upd_q),
  .cnt      (cnt_val),
  .tov      (tov_q)
);

// File: tb/sim_kwd_top.sv
module sim_kwd_top;
  localparam int CNT_W = 24;
  localparam int WIN   = 32;
  localparam int DEF   = 60000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  kwd_top #(.CNT_W(CNT_W), .WIN(WIN), .DEF_TOVAL(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_reset();
    rd(4'h0, v); chk("R1 ctrl", v, 32'h2020);
    rd(4'h4, v); chk("R1 cnt", v, 0);
    rd(4'h8, v); chk("R1 limit", v, DEF);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    rd(4'hC, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    do_reset();
    wr(4'h8, 32'd9);
    rd(4'h8, v); chk("R7 limit locked", v, DEF);
    wr(4'h0, 32'h0000_00A0);
    rd(4'h0, v); chk("R7 ctrl locked", v, 32'h2020);
    ticks(3);
    rd(4'h4, v); chk("R10 disabled", v, 0);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); chk("R3 unlock open", v, 32'h2820);
    wr(4'h8, 32'd5);
    rd(4'h8, v); chk("R8 limit in window", v, 5);
    wr(4'h0, 32'h0000_22A0);
    rd(4'h0, v); chk("R2 R8 ctrl fields", v, 32'h26A0);
    ticks(3);
    rd(4'h4, v); chk("R10 count", v, 3);
    wr(4'h4, 32'hB480_A602);
    rd(4'h4, v); chk("R3 refresh", v, 0);
    ticks(5);
    rd(4'h4, v); chk("R11 at limit", v, 5);
    chk("R11 not yet", {31'b0, rst_req}, 0);
    idle(1);
    chk("R11 one cycle later", {31'b0, rst_req}, 1);
    wr(4'h4, 32'hB480_A602);
    idle(2);
    chk("R11 sticky", {31'b0, rst_req}, 1);
  endtask

  task automatic t_bad32;
    do_reset();
    wr(4'h4, 32'h1234_5678);
    chk("R6 wrong 32-bit key", {31'b0, rst_req}, 1);
  endtask

  task automatic setup16;
    wr(4'h4, 32'hD928_C520);
    wr(4'h8, 32'd1000);
    wr(4'h0, 32'h0000_00A0);
  endtask

  task automatic t_mode16;
    logic [31:0] v;
    do_reset();
    setup16();
    rd(4'h0, v); chk("R2 16-bit ctrl", v, 32'h04A0);
    ticks(2);
    wr(4'h4, 32'h0000_A602);
    rd(4'h4, v); chk("R4 first half holds", v, 2);
    wr(4'h4, 32'h0000_B480);
    rd(4'h4, v); chk("R4 refresh halves", v, 0);
    ticks(1);
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_D928);
    rd(4'h0, v); chk("R4 unlock halves", v, 32'h08A0);
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_1234);
    rd(4'h0, v); chk("R5 window closed", v, 32'h00A0);
    chk("R5 no reset", {31'b0, rst_req}, 0);
    rd(4'h4, v); chk("R5 count kept", v, 1);
    wr(4'h4, 32'h0000_A602);
    wr(4'h8, 32'd3);
    wr(4'h4, 32'h0000_B480);
    chk("R4 R6 broken pair", {31'b0, rst_req}, 1);
  endtask

  task automatic t_updlock;
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'hFFFF_FFDF);
    rd(4'h0, v); chk("R2 R9 ctrl", v, 32'h2780);
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); chk("R9 unlock refused", v, 32'h2780);
    chk("R9 no reset", {31'b0, rst_req}, 0);
    wr(4'h8, 32'd7);
    rd(4'h8, v); chk("R9 limit kept", v, DEF);
  endtask

  task automatic t_window;
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    idle(WIN + 2);
    rd(4'h0, v); chk("R8 window expired", v, 32'h2020);
    wr(4'h8, 32'd9);
    rd(4'h8, v); chk("R7 R8 late write", v, DEF);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_locked();
    t_timeout();
    t_bad32();
    t_mode16();
    t_updlock();
    t_window();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule